// File: doc/BRIEF.md
# Coalescing Store Buffer with Read Bypass

This block sits between a write-through cache and the next level of memory. Stores from the cache enter a small queue of pending word writes, each kept with its target address and a per-byte strobe mask. The processor is released as soon as a store is queued. The queue empties toward memory in arrival order through one shared request port whenever no read needs that port. A store to an address that is already queued folds its strobed bytes into the existing slot and does not take a new one.

Read misses from the cache are searched against every queued address at once. When the matching slot holds a full word, its data returns without any memory access. A read that matches nothing goes to memory ahead of all queued stores. A read that matches a slot with only some bytes written waits while the queue drains past that slot, and then reads memory. A store and a read to the same address accepted in the same cycle are ordered store first.

Top module: `coalesce_wbuf`

## Requirements
- R1: After reset the queue is empty: `memReqValid`=0, `wrReady`=1, `rdReady`=1, `rdRespValid`=0.
- R2: Queued stores are offered on the memory port (`memReqWrite`=1) oldest first, carrying their address, data and strobe mask. Each `memAck` on a store offer removes exactly that slot.
- R3: When all DEPTH slots are occupied and the incoming store matches no slot, `wrReady` is 0. A slot removed by `memAck` in the same cycle frees room, and `wrReady` is then 1.
- R4: A store whose address matches a queued slot merges into it: bytes whose `wrStrb` bit is 1 take the new data, the strobe mask becomes the OR of both masks, and the slot keeps its place in order. This also applies when the queue is full. The exception is the oldest slot in a cycle where `memAck` removes it; in that case the store takes a new slot.
- R5: `rdReady` is 1 exactly when no read is outstanding. Each accepted read produces one single-cycle `rdRespValid` pulse, after which `rdReady` is 1.
- R6: A read whose address matches a slot with all strobe bits set returns that slot's data, with `rdRespValid` in the second cycle after acceptance, and issues no memory read.
- R7: A read matching no slot is offered to memory (`memReqValid`=1, `memReqWrite`=0, `memReqAddr`=read address) ahead of any queued store. `rdRespData` equals `memRdata` from the acknowledged cycle and appears one cycle after that `memAck`.
- R8: A read matching a slot with some strobe bits clear does not forward. Stores keep draining until that slot has been written to memory, and then the read goes to memory and returns the merged memory word.
- R9: A store and a read to the same address accepted in the same cycle are ordered store first, so the read observes the stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrValid | input | 1 | Store request present |
| wrReady | output | 1 | Store accepted this cycle when high with wrValid |
| wrAddr | input | AW | Store word address |
| wrData | input | DW | Store data |
| wrStrb | input | DW/8 | Store byte enables |
| rdValid | input | 1 | Read-miss request present |
| rdReady | output | 1 | No read outstanding; read accepted when high with rdValid |
| rdAddr | input | AW | Read-miss address |
| rdRespValid | output | 1 | Single-cycle read response strobe |
| rdRespData | output | DW | Read response word |
| memReqValid | output | 1 | Memory request offered |
| memReqWrite | output | 1 | 1 = store drain, 0 = read |
| memReqAddr | output | AW | Memory request address |
| memReqData | output | DW | Store data of the oldest slot |
| memReqStrb | output | DW/8 | Byte enables of the oldest slot |
| memAck | input | 1 | Memory takes the request offered this cycle |
| memRdata | input | DW | Read data, valid with memAck on a read |

## Verification
The bench aims at the cycles where two paths meet. One is a store that hits the oldest slot while memory acknowledges that slot: a design that merged there would lose the new bytes. Another is a full queue that is draining in the same cycle: a wrong design would stall a store that had room. Partial-strobe hits test the forwarding path, since a design that forwarded them would return a word with stale bytes. A read arriving with a same-address store tests ordering, because a design that searched before writing would miss the new data. Bypass reads with stores waiting check that the memory port goes to the read first and that the queue order survives the interruption.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

  // Strobes from the control unit to the slot storage, one cycle's worth.
  typedef struct packed {
    logic alloc;    // store takes the slot at the tail pointer
    logic merge;    // store folds into the slot flagged by mergeVec
    logic pop;      // oldest slot leaves toward memory
    logic respFwd;  // register a forwarded read response
    logic respMem;  // register a response taken from memory
  } wbufCtrl_t;

endpackage

// File: rtl/wbuf_store.sv
module wbuf_store
  import wbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int BW   = DW / 8,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  wbufCtrl_t        ctrl,
  input  logic [DEPTH-1:0] mergeVec,
  input  logic [IW-1:0]    headIdx,
  input  logic [IW-1:0]    tailIdx,
  input  logic [AW-1:0]    wrAddr,
  input  logic [DW-1:0]    wrData,
  input  logic [BW-1:0]    wrStrb,
  input  logic [AW-1:0]    lookAddr,
  input  logic [DW-1:0]    memRdata,
  output logic [DEPTH-1:0] wrMatchVec,
  output logic             lookHit,
  output logic             lookFull,
  output logic [AW-1:0]    headAddr,
  output logic [DW-1:0]    headData,
  output logic [BW-1:0]    headStrb,
  output logic             respValid,
  output logic [DW-1:0]    respData
);

  logic [AW-1:0]    slotAddr [DEPTH];
  logic [DW-1:0]    slotData [DEPTH];
  logic [BW-1:0]    slotStrb [DEPTH];
  logic [DW-1:0]    slotMerged [DEPTH];
  logic [DEPTH-1:0] slotValid;
  logic [DEPTH-1:0] lookMatchVec;
  logic [DEPTH-1:0] lookFullVec;
  logic [DW-1:0]    lookData;

  // Associative compare and byte merge, one copy per slot.
  for (genvar s = 0; s < DEPTH; s++) begin : gSlot
    assign wrMatchVec[s]   = slotValid[s] && (slotAddr[s] == wrAddr);
    assign lookMatchVec[s] = slotValid[s] && (slotAddr[s] == lookAddr);
    assign lookFullVec[s]  = lookMatchVec[s] && (&slotStrb[s]);
    for (genvar b = 0; b < BW; b++) begin : gByte
      assign slotMerged[s][b*8 +: 8] = wrStrb[b] ? wrData[b*8 +: 8]
                                                 : slotData[s][b*8 +: 8];
    end
  end

  // At most one slot holds a given address, so an OR gathers the hit data.
  always_comb begin
    lookData = '0;
    for (int s = 0; s < DEPTH; s++) begin
      if (lookMatchVec[s]) lookData = lookData | slotData[s];
    end
  end

  assign lookHit  = |lookMatchVec;
  assign lookFull = |lookFullVec;
  assign headAddr = slotAddr[headIdx];
  assign headData = slotData[headIdx];
  assign headStrb = slotStrb[headIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotValid <= '0;
      for (int s = 0; s < DEPTH; s++) begin
        slotAddr[s] <= '0;
        slotData[s] <= '0;
        slotStrb[s] <= '0;
      end
    end else begin
      for (int s = 0; s < DEPTH; s++) begin
        // Clear first so a same-slot alloc in a full, draining queue wins.
        if (ctrl.pop && (headIdx == IW'(s))) slotValid[s] <= 1'b0;
        if (ctrl.alloc && (tailIdx == IW'(s))) begin
          slotValid[s] <= 1'b1;
          slotAddr[s]  <= wrAddr;
          slotData[s]  <= wrData;
          slotStrb[s]  <= wrStrb;
        end else if (ctrl.merge && mergeVec[s]) begin
          slotData[s]  <= slotMerged[s];
          slotStrb[s]  <= slotStrb[s] | wrStrb;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respData  <= '0;
    end else begin
      respValid <= ctrl.respFwd || ctrl.respMem;
      if (ctrl.respFwd)      respData <= lookData;
      else if (ctrl.respMem) respData <= memRdata;
    end
  end

endmodule

// File: rtl/wbuf_ctrl.sv
module wbuf_ctrl
  import wbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrValid,
  input  logic             rdValid,
  input  logic [AW-1:0]    rdAddr,
  input  logic             memAck,
  input  logic [DEPTH-1:0] wrMatchVec,
  input  logic             lookHit,
  input  logic             lookFull,
  output wbufCtrl_t        ctrl,
  output logic [DEPTH-1:0] mergeVec,
  output logic [IW-1:0]    headIdx,
  output logic [IW-1:0]    tailIdx,
  output logic [AW-1:0]    lookAddr,
  output logic             wrReady,
  output logic             rdReady,
  output logic             memIsRead,
  output logic             nonEmpty
);

  localparam logic [IW:0] FULL_CNT = (IW+1)'(DEPTH);

  logic [IW:0]      countQ;
  logic [IW-1:0]    headQ, tailQ;
  logic             pendQ;
  logic [AW-1:0]    pendAddrQ;
  logic [DEPTH-1:0] headHot;
  logic [IW:0]      countAfterPop;
  logic             anyMerge, wrFire;

  function automatic logic [IW-1:0] stepIdx(input logic [IW-1:0] idx);
    return (idx == IW'(DEPTH - 1)) ? '0 : idx + 1'b1;
  endfunction

  for (genvar s = 0; s < DEPTH; s++) begin : gHead
    assign headHot[s] = (headQ == IW'(s));
  end

  assign nonEmpty  = (countQ != '0);
  // A waiting read that hits nothing owns the memory port.
  assign memIsRead = pendQ && !lookHit;
  assign ctrl.pop  = memAck && nonEmpty && !memIsRead;

  // The oldest slot cannot absorb a store in the cycle it is leaving.
  assign mergeVec      = wrMatchVec & ~(ctrl.pop ? headHot : '0);
  assign anyMerge      = |mergeVec;
  assign countAfterPop = countQ - (IW+1)'(ctrl.pop);
  assign wrReady       = anyMerge || (countAfterPop < FULL_CNT);
  assign wrFire        = wrValid && wrReady;

  assign ctrl.merge   = wrFire && anyMerge;
  assign ctrl.alloc   = wrFire && !anyMerge;
  assign ctrl.respFwd = pendQ && lookHit && lookFull;
  assign ctrl.respMem = memIsRead && memAck;

  assign rdReady  = !pendQ;
  assign lookAddr = pendAddrQ;
  assign headIdx  = headQ;
  assign tailIdx  = tailQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ    <= '0;
      headQ     <= '0;
      tailQ     <= '0;
      pendQ     <= 1'b0;
      pendAddrQ <= '0;
    end else begin
      countQ <= countQ + (IW+1)'(ctrl.alloc) - (IW+1)'(ctrl.pop);
      if (ctrl.pop)   headQ <= stepIdx(headQ);
      if (ctrl.alloc) tailQ <= stepIdx(tailQ);
      if (rdValid && rdReady) begin
        pendQ     <= 1'b1;
        pendAddrQ <= rdAddr;
      end else if (ctrl.respFwd || ctrl.respMem) begin
        pendQ     <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/coalesce_wbuf.sv
module coalesce_wbuf
  import wbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int BW   = DW / 8,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrValid,
  output logic          wrReady,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic [BW-1:0] wrStrb,
  input  logic          rdValid,
  output logic          rdReady,
  input  logic [AW-1:0] rdAddr,
  output logic          rdRespValid,
  output logic [DW-1:0] rdRespData,
  output logic          memReqValid,
  output logic          memReqWrite,
  output logic [AW-1:0] memReqAddr,
  output logic [DW-1:0] memReqData,
  output logic [BW-1:0] memReqStrb,
  input  logic          memAck,
  input  logic [DW-1:0] memRdata
);

  wbufCtrl_t        ctrl;
  logic [DEPTH-1:0] mergeVec, wrMatchVec;
  logic [IW-1:0]    headIdx, tailIdx;
  logic [AW-1:0]    lookAddr, headAddr;
  logic             lookHit, lookFull, memIsRead, nonEmpty;

  wbuf_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
    .clk, .rstN, .wrValid, .rdValid, .rdAddr, .memAck,
    .wrMatchVec, .lookHit, .lookFull,
    .ctrl, .mergeVec, .headIdx, .tailIdx, .lookAddr,
    .wrReady, .rdReady, .memIsRead, .nonEmpty
  );

  wbuf_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
    .clk, .rstN, .ctrl, .mergeVec, .headIdx, .tailIdx,
    .wrAddr, .wrData, .wrStrb, .lookAddr, .memRdata,
    .wrMatchVec, .lookHit, .lookFull,
    .headAddr, .headData(memReqData), .headStrb(memReqStrb),
    .respValid(rdRespValid), .respData(rdRespData)
  );

  assign memReqValid = memIsRead || nonEmpty;
  assign memReqWrite = !memIsRead;
  assign memReqAddr  = memIsRead ? lookAddr : headAddr;

endmodule

// File: rtl/wbuf_checker.sv
module wbuf_checker (
  input logic clk,
  input logic rstN,
  input logic wrValid,
  input logic wrReady,
  input logic rdReady,
  input logic rdRespValid,
  input logic memReqValid,
  input logic memReqWrite,
  input logic memAck
);

  // R2: an unacknowledged store offer is still offered next cycle
  assert_drain_persists_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqWrite && !memAck) |=> memReqValid);

  // R3: a refused store implies a non-empty queue
  assert_stall_nonempty_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |-> memReqValid);

  // R5: responses are single-cycle pulses
  assert_resp_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    rdRespValid |=> !rdRespValid);

  // R5: a response leaves the read port free
  assert_resp_frees_R5: assert property (@(posedge clk) disable iff (!rstN)
    rdRespValid |-> rdReady);

  // R6: a response follows a cycle in which a read was outstanding
  assert_resp_after_wait_R6: assert property (@(posedge clk) disable iff (!rstN)
    rdRespValid |-> $past(!rdReady));

  // R7: a memory read is offered only while a read is outstanding
  assert_read_owner_R7: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqWrite) |-> !rdReady);

endmodule

bind coalesce_wbuf wbuf_checker u_chk (.*);

// File: tb/sim_coalesce_wbuf.sv
module sim_coalesce_wbuf;

  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rstN;
  logic        wrValid, wrReady, rdValid, rdReady, rdRespValid;
  logic [31:0] wrAddr, wrData, rdAddr, rdRespData;
  logic [3:0]  wrStrb, memReqStrb;
  logic        memReqValid, memReqWrite, memAck;
  logic [31:0] memReqAddr, memReqData, memRdata;

  always #10 clk = ~clk;

  coalesce_wbuf #(.DEPTH(DEPTH), .AW(32), .DW(32)) u0 (.*);

  typedef struct {
    logic [31:0] a;
    logic [31:0] d;
    logic [3:0]  s;
  } ent_t;

  ent_t        mq[$];
  logic [31:0] memArr [logic [31:0]];
  logic        mPend, mRespV;
  logic [31:0] mPendA, mRespD;
  int          errors, checks;

  logic        obsWrReady, obsRdReady, obsMV, obsMW, obsRespV;
  logic [31:0] obsMA, obsMD, obsRespD;
  logic [3:0]  obsMS;

  function automatic logic [31:0] seedOf(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5BD1E995;
  endfunction

  function automatic logic [31:0] memRead(input logic [31:0] a);
    return memArr.exists(a) ? memArr[a] : seedOf(a);
  endfunction

  function automatic logic [31:0] byteMerge(input logic [31:0] oldD, newD,
                                             input logic [3:0] s);
    logic [31:0] r = oldD;
    for (int b = 0; b < 4; b++) if (s[b]) r[b*8 +: 8] = newD[b*8 +: 8];
    return r;
  endfunction

  function automatic int findAddr(input logic [31:0] a, input int from);
    for (int i = from; i < mq.size(); i++) if (mq[i].a == a) return i;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One clock: drive at falling edge, compare with the model, advance both.
  task automatic tick(input logic wv, input logic [31:0] wa, input logic [31:0] wd,
                      input logic [3:0] ws, input logic rv, input logic [31:0] ra,
                      input logic ack);
    int   rdIdx, wIdx;
    logic isRd, pop, eMV, eWrReady, fwd;
    logic [31:0] eMA;
    @(negedge clk);
    wrValid = wv; wrAddr = wa; wrData = wd; wrStrb = ws;
    rdValid = rv; rdAddr = ra; memAck = ack;
    memRdata = memRead(mPendA);
    #1;
    rdIdx    = mPend ? findAddr(mPendA, 0) : -1;
    isRd     = mPend && (rdIdx < 0);
    eMV      = isRd || (mq.size() > 0);
    eMA      = isRd ? mPendA : ((mq.size() > 0) ? mq[0].a : 32'h0);
    pop      = ack && !isRd && (mq.size() > 0);
    wIdx     = findAddr(wa, pop ? 1 : 0);
    eWrReady = (wIdx >= 0) || ((mq.size() - int'(pop)) < DEPTH);

    obsWrReady = wrReady; obsRdReady = rdReady; obsMV = memReqValid;
    obsMW = memReqWrite; obsMA = memReqAddr; obsMD = memReqData; obsMS = memReqStrb;
    obsRespV = rdRespValid; obsRespD = rdRespData;

    chk(wrReady == eWrReady, "R3", "wrReady", 32'(wrReady), 32'(eWrReady));
    chk(rdReady == !mPend, "R5", "rdReady", 32'(rdReady), 32'(!mPend));
    chk(rdRespValid == mRespV, "R5", "rdRespValid", 32'(rdRespValid), 32'(mRespV));
    if (mRespV) chk(rdRespData == mRespD, "R6", "rdRespData", rdRespData, mRespD);
    chk(memReqValid == eMV, "R7", "memReqValid", 32'(memReqValid), 32'(eMV));
    if (eMV) begin
      chk(memReqWrite == !isRd, "R7", "memReqWrite", 32'(memReqWrite), 32'(!isRd));
      chk(memReqAddr == eMA, "R2", "memReqAddr", memReqAddr, eMA);
      if (!isRd) begin
        chk(memReqData == mq[0].d, "R2", "memReqData", memReqData, mq[0].d);
        chk(memReqStrb == mq[0].s, "R2", "memReqStrb", 32'(memReqStrb), 32'(mq[0].s));
      end
    end

    fwd = mPend && (rdIdx >= 0) && (mq[rdIdx].s == 4'hF);
    mRespV = 1'b0;
    if (fwd) begin
      mRespV = 1'b1; mRespD = mq[rdIdx].d; mPend = 1'b0;
    end else if (isRd && ack) begin
      mRespV = 1'b1; mRespD = memRead(mPendA); mPend = 1'b0;
    end else if (rv && !mPend) begin
      mPend = 1'b1; mPendA = ra;
    end
    if (pop) begin
      memArr[mq[0].a] = byteMerge(memRead(mq[0].a), mq[0].d, mq[0].s);
      void'(mq.pop_front());
    end
    if (wv && eWrReady) begin
      if (wIdx >= 0) begin
        int k = wIdx - int'(pop);
        mq[k].d = byteMerge(mq[k].d, wd, ws);
        mq[k].s = mq[k].s | ws;
      end else begin
        ent_t e;
        e.a = wa; e.d = wd; e.s = ws;
        mq.push_back(e);
      end
    end
    @(posedge clk);
  endtask

  task automatic idle(input logic ack);
    tick(1'b0, 32'h0, 32'h0, 4'h0, 1'b0, 32'h0, ack);
  endtask

  task automatic flush();
    for (int i = 0; i < 12; i++) idle(1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    errors = 0; checks = 0;
    mPend = 1'b0; mRespV = 1'b0; mPendA = '0; mRespD = '0;
    rstN = 1'b0; wrValid = 0; wrAddr = 0; wrData = 0; wrStrb = 0;
    rdValid = 0; rdAddr = 0; memAck = 0; memRdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: empty after reset
    chk(memReqValid == 1'b0, "R1", "memReqValid", 32'(memReqValid), 32'h0);
    chk(wrReady == 1'b1, "R1", "wrReady", 32'(wrReady), 32'h1);
    chk(rdReady == 1'b1, "R1", "rdReady", 32'(rdReady), 32'h1);
    chk(rdRespValid == 1'b0, "R1", "rdRespValid", 32'(rdRespValid), 32'h0);

    // R4: two partial stores fold into one slot that keeps its place
    tick(1, 32'h10, 32'h11111111, 4'b0011, 0, 0, 0);
    tick(1, 32'h10, 32'h22222222, 4'b1100, 0, 0, 0);
    tick(1, 32'h14, 32'h33333333, 4'b1111, 0, 0, 0);
    idle(0);
    chk(obsMA == 32'h10 && obsMD == 32'h22221111 && obsMS == 4'hF, "R4",
        "merged head data", obsMD, 32'h22221111);
    idle(1);
    idle(0);
    chk(obsMV && obsMW && obsMA == 32'h14, "R2", "second slot next", obsMA, 32'h14);
    flush();

    // R4: store to the head while it is acknowledged takes a fresh slot
    tick(1, 32'h18, 32'hAAAA0000, 4'hF, 0, 0, 0);
    tick(1, 32'h18, 32'hBBBBBBBB, 4'hF, 0, 0, 1);
    idle(0);
    chk(obsMV && obsMA == 32'h18 && obsMD == 32'hBBBBBBBB, "R4",
        "store beside popping head", obsMD, 32'hBBBBBBBB);
    flush();

    // R3: full queue stalls a new address, accepts a merge, frees on drain
    tick(1, 32'h20, 32'h1, 4'hF, 0, 0, 0);
    tick(1, 32'h24, 32'h2, 4'hF, 0, 0, 0);
    tick(1, 32'h28, 32'h3, 4'hF, 0, 0, 0);
    tick(1, 32'h2C, 32'h4, 4'hF, 0, 0, 0);
    tick(1, 32'h30, 32'h5, 4'hF, 0, 0, 0);
    chk(obsWrReady == 1'b0, "R3", "full stall", 32'(obsWrReady), 32'h0);
    tick(1, 32'h24, 32'h6, 4'hF, 0, 0, 0);
    chk(obsWrReady == 1'b1, "R4", "merge while full", 32'(obsWrReady), 32'h1);
    tick(1, 32'h30, 32'h5, 4'hF, 0, 0, 1);
    chk(obsWrReady == 1'b1, "R3", "room from same-cycle drain", 32'(obsWrReady), 32'h1);
    flush();

    // R6: full-word hit forwards without a memory read
    tick(1, 32'h40, 32'hCAFEF00D, 4'hF, 0, 0, 0);
    tick(0, 0, 0, 0, 1, 32'h40, 0);
    idle(0);
    chk(obsMV && obsMW, "R6", "no memory read on hit", 32'(obsMW), 32'h1);
    idle(0);
    chk(obsRespV && obsRespD == 32'hCAFEF00D, "R6", "forwarded data", obsRespD, 32'hCAFEF00D);

    // R7: miss bypasses the waiting store
    tick(0, 0, 0, 0, 1, 32'h50, 0);
    idle(0);
    chk(obsMV && !obsMW && obsMA == 32'h50, "R7", "read ahead of store", obsMA, 32'h50);
    chk(obsRdReady == 1'b0, "R5", "rdReady while outstanding", 32'(obsRdReady), 32'h0);
    idle(1);
    idle(0);
    chk(obsRespV && obsRespD == seedOf(32'h50), "R7", "memory read data",
        obsRespD, seedOf(32'h50));
    chk(obsMV && obsMW && obsMA == 32'h40, "R7", "store resumes", obsMA, 32'h40);
    flush();

    // R8: partial hit waits for the drain, then reads the merged word
    tick(1, 32'h60, 32'h000000AB, 4'b0001, 0, 0, 0);
    tick(0, 0, 0, 0, 1, 32'h60, 0);
    idle(0);
    chk(obsMV && obsMW && obsMA == 32'h60, "R8", "drain before read", 32'(obsMW), 32'h1);
    idle(1);
    idle(0);
    chk(obsMV && !obsMW && obsMA == 32'h60, "R8", "read after drain", 32'(obsMW), 32'h0);
    idle(1);
    idle(0);
    chk(obsRespV && obsRespD == ((seedOf(32'h60) & 32'hFFFFFF00) | 32'hAB), "R8",
        "merged memory word", obsRespD, (seedOf(32'h60) & 32'hFFFFFF00) | 32'hAB);
    flush();

    // R9: same-cycle store and read, store first
    tick(1, 32'h70, 32'h5A5A1234, 4'hF, 1, 32'h70, 0);
    idle(0);
    idle(0);
    chk(obsRespV && obsRespD == 32'h5A5A1234, "R9", "read sees same-cycle store",
        obsRespD, 32'h5A5A1234);
    flush();

    // Mixed traffic over a small address set at three acknowledge rates
    for (int seg = 0; seg < 3; seg++) begin
      int ackPct = (seg == 0) ? 15 : ((seg == 1) ? 50 : 90);
      for (int c = 0; c < 600; c++) begin
        logic [3:0] s = 4'($urandom_range(1, 15));
        if ($urandom_range(0, 2) == 0) s = 4'hF;
        tick(($urandom_range(0, 99) < 55),
             32'h100 + 32'($urandom_range(0, 5)) * 4, $urandom, s,
             ($urandom_range(0, 99) < 30),
             32'h100 + 32'($urandom_range(0, 7)) * 4,
             ($urandom_range(0, 99) < ackPct));
      end
    end
    flush();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule